// File: doc/BRIEF.md
# Multi-Channel DMA Interrupt Generator

This block turns per-channel DMA events into one level-sensitive interrupt line. Each channel can report a descriptor completion, which carries the descriptor's own interrupt request bit, or an error. Either event may arrive while the descriptor's status is still being written back to memory. In that case the event is parked and takes effect only when the channel signals that its write-back has finished.

Qualifying events set a sticky per-channel flag. Software reads the flags and clears them by writing ones. The interrupt output combines the flags with a layered set of enables:
- a global enable;
- an error enable that gates error flags;
- a per-channel mask that gates completion flags.

Software reaches the enables, the mask and the flags through a small APB-style register port.

Top module: `dma_irq_gen`

## Requirements
- R1: While the global enable (control register at offset 0x0, bit 0) is 0, `irq` is 0 whatever the flags, mask and error enable hold.
- R2: A flag raised by an error drives `irq` only while the error enable (offset 0x0, bit 1) and the global enable are both 1. The flag itself is set regardless of either enable.
- R3: A completion whose descriptor request bit (`cmp_ie`) is 0 sets no flag.
- R4: With its mask bit (offset 0x4, bit = channel number) at 0, a channel's completion flag does not drive `irq`. The flag is still set and still readable.
- R5: An event presented with its write-back-pending bit set leaves the flag unchanged until a `wb_done` pulse arrives on that channel. The flag is set on the clock edge that samples `wb_done`. A `wb_done` on another channel does not release it.
- R6: An event without write-back pending sets the flag at offset 0x8, bit = channel number, on the clock edge that samples it.
- R7: Writing 1 to a flag bit at offset 0x8 clears it, and writing 0 leaves it unchanged. A clear and a new event on the same channel in the same cycle leave the flag set.
- R8: `irq` is a level equal to the OR of all flags passing their enables, derived from registers only.
- R9: After reset the control, mask and flag registers read 0. Reads of offset 0xC return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte address; bits [3:2] pick the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational |
| cmp_valid | input | NCH | Per-channel completion pulse |
| cmp_ie | input | NCH | Descriptor interrupt request bit of the completion |
| cmp_wb_pend | input | NCH | Completion status write-back still in progress |
| err_valid | input | NCH | Per-channel error pulse |
| err_wb_pend | input | NCH | Error status write-back still in progress |
| wb_done | input | NCH | Per-channel write-back finished pulse |
| irq | output | 1 | Interrupt level |

## Verification
On every cycle the assertions check four things:
- the global enable forces the line low;
- a raised line with the error enable off always has a masked-in flag behind it;
- a flag never rises without a qualifying event, and it is never lost without a write-one clear;
- the line is never high with all flags clear.

The scenarios cover the parts no single-cycle property can show. A deferred event waits through an unrelated channel's `wb_done` and is released by its own. A completion with a zero request bit leaves no trace. A write of zeros to the flags is harmless. A same-cycle clear and set resolves in favour of the set.

// File: rtl/dma_irq_gen.sv
module dma_irq_gen #(
  parameter int NCH = 8,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [31:0]    pwdata,
  output logic [31:0]    prdata,
  input  logic [NCH-1:0] cmp_valid,
  input  logic [NCH-1:0] cmp_ie,
  input  logic [NCH-1:0] cmp_wb_pend,
  input  logic [NCH-1:0] err_valid,
  input  logic [NCH-1:0] err_wb_pend,
  input  logic [NCH-1:0] wb_done,
  output logic           irq
);
  localparam logic [1:0] A_CTRL = 2'd0, A_MASK = 2'd1, A_FLAG = 2'd2;

  logic           gie_q, iee_q;
  logic [NCH-1:0] mask_q, fcmp_q, ferr_q, pcmp_q, perr_q;
  logic [NCH-1:0] flags, clr, set_cmp, set_err;
  logic [1:0]     idx;
  logic           wr;

  assign idx   = paddr[3:2];
  assign wr    = psel & penable & pwrite;
  assign flags = fcmp_q | ferr_q;
  assign clr   = (wr && idx == A_FLAG) ? pwdata[NCH-1:0] : '0;

  assign set_cmp = (cmp_valid & cmp_ie & ~cmp_wb_pend) | (pcmp_q & wb_done);
  assign set_err = (err_valid & ~err_wb_pend) | (perr_q & wb_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      iee_q  <= 1'b0;
      mask_q <= '0;
      fcmp_q <= '0;
      ferr_q <= '0;
      pcmp_q <= '0;
      perr_q <= '0;
    end else begin
      if (wr && idx == A_CTRL) begin
        gie_q <= pwdata[0];
        iee_q <= pwdata[1];
      end
      if (wr && idx == A_MASK) mask_q <= pwdata[NCH-1:0];
      fcmp_q <= (fcmp_q & ~clr) | set_cmp;
      ferr_q <= (ferr_q & ~clr) | set_err;
      pcmp_q <= (pcmp_q & ~wb_done) | (cmp_valid & cmp_ie & cmp_wb_pend);
      perr_q <= (perr_q & ~wb_done) | (err_valid & err_wb_pend);
    end
  end

  always_comb begin
    case (idx)
      A_CTRL:  prdata = {30'd0, iee_q, gie_q};
      A_MASK:  prdata = 32'(mask_q);
      A_FLAG:  prdata = 32'(flags);
      default: prdata = 32'd0;
    endcase
  end

  assign irq = gie_q & |((fcmp_q & mask_q) | (ferr_q & {NCH{iee_q}}));
endmodule

module dma_irq_gen_chk #(parameter int NCH = 8) (
  input logic           clk,
  input logic           rst_n,
  input logic           gie,
  input logic           iee,
  input logic [NCH-1:0] mask,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] clr,
  input logic [NCH-1:0] cmp_valid,
  input logic [NCH-1:0] cmp_ie,
  input logic [NCH-1:0] err_valid,
  input logic [NCH-1:0] wb_done,
  input logic           irq
);
  a_r1_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);

  a_r4_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !iee) |-> ((flags & mask) != '0));

  a_r3_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past((cmp_valid & cmp_ie) | err_valid | wb_done)) == '0));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags) & ~$past(clr) & ~flags) == '0));

  a_r8_level_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && flags != '0));
endmodule

bind dma_irq_gen dma_irq_gen_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie_q), .iee(iee_q), .mask(mask_q),
  .flags(flags), .clr(clr), .cmp_valid(cmp_valid), .cmp_ie(cmp_ie),
  .err_valid(err_valid), .wb_done(wb_done), .irq(irq)
);

// File: tb/dma_irq_gen_tb.sv
`timescale 1ns/1ps
module dma_irq_gen_tb;
  localparam int NCH = 8;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [3:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [NCH-1:0] cmp_valid = '0, cmp_ie = '0, cmp_wb_pend = '0;
  logic [NCH-1:0] err_valid = '0, err_wb_pend = '0, wb_done = '0;
  logic irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dma_irq_gen #(.NCH(NCH), .AW(4)) u_dut (.*);

  // behavioural reference state
  bit m_gie, m_iee;
  bit [NCH-1:0] m_mask, m_fc, m_fe, m_pc, m_pe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gie = 0; m_iee = 0; m_mask = 0; m_fc = 0; m_fe = 0; m_pc = 0; m_pe = 0;
    end else begin
      bit w;
      w = psel && penable && pwrite;
      for (int c = 0; c < NCH; c++) begin
        bit cl, sc, se;
        cl = w && paddr[3:2] == 2 && pwdata[c];
        sc = (cmp_valid[c] && cmp_ie[c] && !cmp_wb_pend[c]) || (m_pc[c] && wb_done[c]);
        se = (err_valid[c] && !err_wb_pend[c]) || (m_pe[c] && wb_done[c]);
        if (cl) begin m_fc[c] = 0; m_fe[c] = 0; end
        if (sc) m_fc[c] = 1;
        if (se) m_fe[c] = 1;
        if (wb_done[c]) begin m_pc[c] = 0; m_pe[c] = 0; end
        if (cmp_valid[c] && cmp_ie[c] && cmp_wb_pend[c]) m_pc[c] = 1;
        if (err_valid[c] && err_wb_pend[c]) m_pe[c] = 1;
      end
      if (w && paddr[3:2] == 0) begin m_gie = pwdata[0]; m_iee = pwdata[1]; end
      if (w && paddr[3:2] == 1) m_mask = pwdata[NCH-1:0];
    end
  end

  function automatic bit model_irq();
    bit r = 0;
    for (int c = 0; c < NCH; c++)
      if ((m_fc[c] && m_mask[c]) || (m_fe[c] && m_iee)) r = 1;
    return r && m_gie;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    #2 chk("R8 per-cycle irq", 32'(irq), 32'(model_irq()));
  end

  task automatic apb_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read_chk(logic [3:0] a, logic [31:0] exp, string req);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 chk(req, prdata, exp);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic cmp_pulse(logic [NCH-1:0] v, logic [NCH-1:0] ie, logic [NCH-1:0] wp);
    @(negedge clk); cmp_valid = v; cmp_ie = ie; cmp_wb_pend = wp;
    @(negedge clk); cmp_valid = 0; cmp_ie = 0; cmp_wb_pend = 0;
  endtask

  task automatic err_pulse(logic [NCH-1:0] v, logic [NCH-1:0] wp);
    @(negedge clk); err_valid = v; err_wb_pend = wp;
    @(negedge clk); err_valid = 0; err_wb_pend = 0;
  endtask

  task automatic done_pulse(logic [NCH-1:0] v);
    @(negedge clk); wb_done = v;
    @(negedge clk); wb_done = 0;
  endtask

  task automatic irq_chk(bit exp, string req);
    #1 chk(req, 32'(irq), 32'(exp));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    apb_read_chk(4'h0, 0, "R9 reset ctrl");
    apb_read_chk(4'h4, 0, "R9 reset mask");
    apb_read_chk(4'h8, 0, "R9 reset flags");
    irq_chk(0, "R9 reset irq");

    apb_write(4'h0, 32'h1);
    apb_write(4'h4, 32'hFF);
    cmp_pulse(8'h04, 8'h04, 8'h00);
    apb_read_chk(4'h8, 32'h04, "R6 completion sets flag ch2");
    irq_chk(1, "R8 irq from ch2");
    apb_write(4'h8, 32'h0);
    apb_read_chk(4'h8, 32'h04, "R7 write zero keeps flag");
    apb_write(4'h8, 32'h04);
    apb_read_chk(4'h8, 32'h00, "R7 write one clears flag");
    irq_chk(0, "R7 irq drops after clear");

    cmp_pulse(8'h08, 8'h00, 8'h00);
    apb_read_chk(4'h8, 32'h00, "R3 descriptor bit zero sets no flag");
    irq_chk(0, "R3 no irq");

    err_pulse(8'h20, 8'h00);
    apb_read_chk(4'h8, 32'h20, "R2 error sets flag with IEE off");
    irq_chk(0, "R2 error irq gated by IEE");
    apb_write(4'h0, 32'h3);
    irq_chk(1, "R2 error irq with IEE on");
    apb_write(4'h8, 32'h20);

    apb_write(4'h4, 32'hFD);
    cmp_pulse(8'h02, 8'h02, 8'h00);
    apb_read_chk(4'h8, 32'h02, "R4 masked channel flag still set");
    irq_chk(0, "R4 masked completion no irq");
    apb_write(4'h4, 32'hFF);
    irq_chk(1, "R4 unmasking raises irq");

    apb_write(4'h0, 32'h2);
    irq_chk(0, "R1 global off forces irq low");
    apb_read_chk(4'h0, 32'h2, "R9 ctrl readback");
    apb_write(4'h0, 32'h3);
    irq_chk(1, "R1 global on restores irq");
    apb_write(4'h8, 32'h02);

    cmp_pulse(8'h01, 8'h01, 8'h01);
    apb_read_chk(4'h8, 32'h00, "R5 pending completion not flagged");
    irq_chk(0, "R5 no irq while write-back pending");
    done_pulse(8'h80);
    apb_read_chk(4'h8, 32'h00, "R5 other channel done does not release");
    done_pulse(8'h01);
    apb_read_chk(4'h8, 32'h01, "R5 own done releases completion");
    irq_chk(1, "R5 irq after write-back");
    err_pulse(8'h40, 8'h40);
    apb_read_chk(4'h8, 32'h01, "R5 pending error not flagged");
    done_pulse(8'h40);
    apb_read_chk(4'h8, 32'h41, "R5 own done releases error");
    apb_write(4'h8, 32'hFF);
    apb_read_chk(4'h8, 32'h00, "R7 clear all");

    cmp_pulse(8'h10, 8'h10, 8'h00);
    @(negedge clk); psel = 1; pwrite = 1; paddr = 4'h8; pwdata = 32'h10; penable = 0;
    @(negedge clk); penable = 1; cmp_valid = 8'h10; cmp_ie = 8'h10;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; cmp_valid = 0; cmp_ie = 0;
    apb_read_chk(4'h8, 32'h10, "R7 same-cycle clear and set keeps flag");

    apb_read_chk(4'hC, 32'h0, "R9 unmapped offset reads zero");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule